// File: doc/BRIEF.md
# Multi-zone temperature limit monitor

This block keeps a programmable low and high temperature limit for each of three zones. Zone 1 is a processor or remote diode, zone 2 is the on-die sensor and zone 3 is a second remote diode. It flags any zone whose reading leaves the window set by those limits. Each limit is one byte in a register that can be read and written over a simple register bus. The measurement front end delivers 8-bit two's-complement readings in whole degrees Celsius, each with its own valid strobe per zone.

A reading that is strictly above its zone's high limit, or strictly below its low limit, sets that zone's bit in a sticky status register. Software clears a status bit by writing a 1 to it. An interrupt output is high whenever any status bit is set. No lock control exists in this block, so the limit registers can always be written.

Top module: `zone_limit_monitor`

## Requirements
- R1: After reset the low limits read 81h (-127), the high limits read 7Fh (+127), the status register at 41h reads 00h and `irq` is low.
- R2: Zone n (n = 1..3) has its low limit at address 4Ch+2n and its high limit at 4Dh+2n, which gives 4Eh..53h in the order z1 low, z1 high, z2 low, z2 high, z3 low, z3 high. A write with `bus_wr` high is stored at the clock edge. Only a write to that exact address changes the register.
- R3: A valid reading whose signed value is greater than its zone's high limit sets status bit n-1 (bit 0 for zone 1, bit 1 for zone 2, bit 2 for zone 3). The bit is visible from the clock edge that samples the reading.
- R4: A valid reading whose signed value is less than its zone's low limit sets the same status bit. Both comparisons are two's-complement, so 80h (-128) lies below the 81h default.
- R5: A reading equal to either limit does not set the status bit. Both comparisons are strict.
- R6: A zone's reading is ignored on any cycle where its valid strobe is low. One zone's reading never sets another zone's bit.
- R7: Status bits are sticky. Writing 1 to bit n-1 of 41h clears that bit and writing 0 leaves it alone. If a set and a clear arrive on the same cycle, the set wins.
- R8: `irq` is high exactly when at least one status bit is set.
- R9: Reads are combinational and return the addressed register in the same cycle. Status bits 7..3 read 0. Unmapped addresses read 00h, and writes to them change no register.
- R10: A reading is compared against the limit values held before the edge that samples it. A limit written on the same cycle as a reading first applies to the next reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| smp_valid | input | 3 | Per-zone reading valid, bit n-1 for zone n |
| smp_temp | input | 24 | Per-zone signed reading, bits 8n-1..8n-8 for zone n |
| irq | output | 1 | OR of the status bits |

## Verification
The assertions take the bus and sample inputs to be known values at every clock edge once reset is released. Those that look one cycle back are masked for the first cycle after reset, so they never refer to values from before reset. The stimulus drives every input from time zero and changes it only on the falling clock edge. All bus inputs stay at zero or idle outside the bus tasks. This keeps every property away from undefined values and race conditions.

// File: rtl/zone_limit_monitor.sv
module zone_limit_monitor #(
  parameter int NZ = 3,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [7:0] LIM_BASE = 8'h4E,
  parameter logic [7:0] STAT_ADDR = 8'h41,
  parameter logic [7:0] LO_RST = 8'h81,
  parameter logic [7:0] HI_RST = 8'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NZ-1:0]    smp_valid,
  input  logic [NZ*DW-1:0] smp_temp,
  output logic             irq
);

  logic [NZ-1:0][DW-1:0] lim_lo, lim_hi;
  logic [NZ-1:0] zstat, hit, clr;

  wire stat_wr = bus_wr && (bus_addr == AW'(STAT_ADDR));

  for (genvar z = 0; z < NZ; z++) begin : g_zone
    wire signed [DW-1:0] t = smp_temp[z*DW +: DW];
    assign hit[z] = smp_valid[z] &&
                    ((t > $signed(lim_hi[z])) || (t < $signed(lim_lo[z])));
    assign clr[z] = stat_wr && bus_wdata[z];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int z = 0; z < NZ; z++) begin
        lim_lo[z] <= DW'(LO_RST);
        lim_hi[z] <= DW'(HI_RST);
      end
      zstat <= '0;
    end else begin
      for (int z = 0; z < NZ; z++) begin
        if (bus_wr && bus_addr == AW'(LIM_BASE + 2*z))     lim_lo[z] <= bus_wdata;
        if (bus_wr && bus_addr == AW'(LIM_BASE + 2*z + 1)) lim_hi[z] <= bus_wdata;
      end
      zstat <= hit | (zstat & ~clr);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(STAT_ADDR)) bus_rdata[NZ-1:0] = zstat;
    for (int z = 0; z < NZ; z++) begin
      if (bus_addr == AW'(LIM_BASE + 2*z))     bus_rdata = lim_lo[z];
      if (bus_addr == AW'(LIM_BASE + 2*z + 1)) bus_rdata = lim_hi[z];
    end
  end

  assign irq = |zstat;

endmodule

// File: rtl/zone_limit_monitor_chk.sv
module zone_limit_monitor_chk #(
  parameter int NZ = 3,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [7:0] LIM_BASE = 8'h4E,
  parameter logic [7:0] STAT_ADDR = 8'h41
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NZ-1:0]    smp_valid,
  input logic [NZ*DW-1:0] smp_temp,
  input logic             irq,
  input logic [NZ-1:0][DW-1:0] lim_lo,
  input logic [NZ-1:0][DW-1:0] lim_hi,
  input logic [NZ-1:0]    zstat
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  wire is_stat = bus_addr == AW'(STAT_ADDR);
  wire mapped  = is_stat || (bus_addr >= AW'(LIM_BASE) && bus_addr < AW'(LIM_BASE + 2*NZ));

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == '0); // R9
  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_stat |-> bus_rdata[DW-1:NZ] == '0); // R9
  AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    is_stat |-> irq == (bus_rdata[NZ-1:0] != '0)); // R8

  for (genvar z = 0; z < NZ; z++) begin : g_chk
    wire signed [DW-1:0] t = smp_temp[z*DW +: DW];
    wire above = t > $signed(lim_hi[z]);
    wire below = t < $signed(lim_lo[z]);

    AST_SET_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(smp_valid[z] && above)) |-> zstat[z]); // R3
    AST_SET_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(smp_valid[z] && below)) |-> zstat[z]); // R4
    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(zstat[z])) |-> $past(smp_valid[z] && (above || below))); // R6
    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $fell(zstat[z])) |-> $past(bus_wr && is_stat && bus_wdata[z])); // R7
    AST_LO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(bus_wr && bus_addr == AW'(LIM_BASE + 2*z))) |-> $stable(lim_lo[z])); // R2
    AST_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(bus_wr && bus_addr == AW'(LIM_BASE + 2*z + 1))) |-> $stable(lim_hi[z])); // R2
  end

endmodule

bind zone_limit_monitor zone_limit_monitor_chk #(
  .NZ(NZ), .DW(DW), .AW(AW), .LIM_BASE(LIM_BASE), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
  .smp_temp(smp_temp), .irq(irq), .lim_lo(lim_lo), .lim_hi(lim_hi), .zstat(zstat)
);

// File: tb/test_zone_limit_monitor.sv
module test_zone_limit_monitor;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic bus_wr = 0;
  logic [7:0] bus_rdata;
  logic [2:0] smp_valid = 0;
  logic [23:0] smp_temp = 0;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  zone_limit_monitor i_zone_limit_monitor (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
    .smp_temp(smp_temp), .irq(irq));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, string req, logic [7:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic sample(int z, logic [7:0] t);
    @(negedge clk); smp_temp = 0; smp_temp[z*8 +: 8] = t; smp_valid = 3'b1 << z;
    @(negedge clk); smp_valid = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int z = 0; z < 3; z++) begin
      rd(8'h4E + 8'(2*z), "R1", 8'h81);
      rd(8'h4F + 8'(2*z), "R1", 8'h7F);
    end
    rd(8'h41, "R1", 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R2 readback of distinct values
    for (int i = 0; i < 6; i++) wr(8'h4E + 8'(i), 8'h10 + 8'(i*3));
    for (int i = 0; i < 6; i++) rd(8'h4E + 8'(i), "R2", 8'h10 + 8'(i*3));

    // R9 unmapped
    wr(8'h54, 8'hAA); wr(8'h4D, 8'hAA); wr(8'h40, 8'hAA);
    for (int i = 0; i < 6; i++) rd(8'h4E + 8'(i), "R9 unmapped write", 8'h10 + 8'(i*3));
    rd(8'h00, "R9", 8'h00); rd(8'h40, "R9", 8'h00); rd(8'h54, "R9", 8'h00); rd(8'hFF, "R9", 8'h00);

    // R3 R4 R5 sweep: per zone, several limit windows, all readings
    for (int z = 0; z < 3; z++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] lo, hi;
        case (p)
          0: begin lo = 8'h81; hi = 8'h7F; end
          1: begin lo = 8'hCE; hi = 8'h32; end
          2: begin lo = 8'h00; hi = 8'h00; end
          default: begin lo = 8'h32; hi = 8'hCE; end
        endcase
        wr(8'h4E + 8'(2*z), lo);
        wr(8'h4F + 8'(2*z), hi);
        for (int v = -128; v < 128; v++) begin
          logic out;
          out = (v > int'($signed(hi))) || (v < int'($signed(lo)));
          sample(z, 8'(v));
          rd(8'h41, (v == int'($signed(hi)) || v == int'($signed(lo))) ? "R5" :
                    (v > int'($signed(hi))) ? "R3" : "R4",
             out ? (8'h01 << z) : 8'h00);
          check("R8 irq", {7'b0, irq}, {7'b0, out});
          if (out) wr(8'h41, 8'hFF);
        end
      end
      wr(8'h4E + 8'(2*z), 8'h81);
      wr(8'h4F + 8'(2*z), 8'h7F);
    end

    // R6 valid low ignored; cross-zone data ignored
    @(negedge clk); smp_temp = {8'h80, 8'h80, 8'h80}; smp_valid = 0;
    @(negedge clk); smp_temp = 0;
    rd(8'h41, "R6", 8'h00);
    @(negedge clk); smp_temp = {8'h80, 8'h00, 8'h00}; smp_valid = 3'b011;
    @(negedge clk); smp_valid = 0; smp_temp = 0;
    rd(8'h41, "R6 cross-zone", 8'h00);

    // R7 sticky, write-0 keeps, selective clear, set wins
    sample(0, 8'h80); sample(2, 8'h80);
    repeat (3) @(negedge clk);
    rd(8'h41, "R7 sticky", 8'h05);
    wr(8'h41, 8'h00);
    rd(8'h41, "R7 write 0", 8'h05);
    wr(8'h41, 8'h01);
    rd(8'h41, "R7 clear one", 8'h04);
    check("R8 irq one", {7'b0, irq}, 8'h01);
    @(negedge clk); bus_addr = 8'h41; bus_wdata = 8'h04; bus_wr = 1;
    smp_temp = {8'h80, 16'h0}; smp_valid = 3'b100;
    @(negedge clk); bus_wr = 0; smp_valid = 0; smp_temp = 0;
    rd(8'h41, "R7 set wins", 8'h04);
    wr(8'h41, 8'hFF);
    rd(8'h41, "R7 clear all", 8'h00);
    check("R8 irq low", {7'b0, irq}, 8'h00);

    // R10 same-cycle limit write uses old limit
    @(negedge clk); bus_addr = 8'h4F; bus_wdata = 8'h00; bus_wr = 1;
    smp_temp = 24'h00000A; smp_valid = 3'b001;
    @(negedge clk); bus_wr = 0; smp_valid = 0;
    rd(8'h41, "R10 old limit", 8'h00);
    sample(0, 8'h0A);
    rd(8'h41, "R10 new limit", 8'h01);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule